// File: doc/BRIEF.md
# Replicated Multithreaded Register File

This block is the architectural register storage for a four-thread processor core that has six functional units. Each thread owns a private context of 32 registers, each 32 bits wide. Each functional unit does not share one heavily multiported array with the others. Instead, each unit has its own local copy of the whole file and reads only from that copy, through two read ports.

Copies are kept identical without any transfer between them. Every result that any unit writes goes into all copies in the same clock cycle. So a value produced by one unit can be read from the next cycle onward by every other unit, each through its own copy.

Six write ports accept one result each per cycle. A register is addressed by its thread number together with its register index. Reads are combinational and see a write of the same cycle. When two write ports hit the same register in one cycle, a fixed priority decides the winner. That outcome is the same in every copy.

Top module: `dup_rf`

## Requirements
- R1: After reset every register of every thread reads as zero on every read port of every copy.
- R2: A value written with write enable high to register (thread t, index i) is returned, from the next cycle on, by every read port of every copy that addresses (t, i), until it is overwritten.
- R3: Thread contexts are separate: a write to (t, i) does not change (u, i) for any other thread u.
- R4: When several enabled write ports target the same (thread, index) in one cycle, the value of the highest-numbered port is stored. Every copy stores that same value.
- R5: A read that addresses a register being written in the same cycle returns the data being written, not the old contents. Under a conflict it returns the data of the winning (highest-numbered) port.
- R6: All twelve read ports, two per copy and six copies, operate at the same time on independent addresses. Each returns the contents of its own address.
- R7: A write port whose enable is low changes no register, whatever its thread, index and data inputs hold.
- R8: Enabled write ports that target different registers all commit in the same cycle.
- R9: The reset input is asynchronous and active low. Release is synchronised internally over two clock edges, and writes presented before release completes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 6 | Write enable, one bit per write port (bit p is port p) |
| wr_tid | input | 12 | Thread number per write port, port p in bits [2p+1:2p] |
| wr_idx | input | 30 | Register index per write port, port p in bits [5p+4:5p] |
| wr_data | input | 192 | Write data per write port, port p in bits [32p+31:32p] |
| rd_tid | input | 24 | Thread number per read port; read port k = 2*copy + local port, bits [2k+1:2k] |
| rd_idx | input | 60 | Register index per read port k, bits [5k+4:5k] |
| rd_data | output | 384 | Read data per read port k, bits [32k+31:32k], valid in the same cycle as its address |

## Verification
The assertions check the following on every cycle:
- All copies return equal data for equal addresses.
- A read that collides with a write on the highest-priority port returns that port's data in the same cycle, and again in the next cycle when nothing overwrites it.
- The read outputs stay stable across any cycle with no writes.
- All outputs are zero in the first cycle after reset.

The bench scenarios are needed for the following:
- Thread isolation.
- Priority among the lower-numbered ports.
- Simultaneous commits to distinct registers.
- Writes lost during the synchronised reset release.

A reference model checks these, together with a long run of conflict-heavy random traffic.

// File: rtl/dup_rf_pkg.sv
package dup_rf_pkg;
  localparam int unsigned THREADS_DEF = 4;
  localparam int unsigned REGS_DEF    = 32;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned WPORTS_DEF  = 6;
  localparam int unsigned COPIES_DEF  = 6;
  localparam int unsigned RPC_DEF     = 2;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 1;
    while ((1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/dup_rf_rst_sync.sv
module dup_rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dup_rf_wr_resolve.sv
// Turns the write ports into one enable and one data word per register.
// Later ports overwrite earlier ones, so the highest-numbered port wins.
module dup_rf_wr_resolve #(
  parameter int unsigned NWR   = 6,
  parameter int unsigned TW    = 2,
  parameter int unsigned IW    = 5,
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic [NWR-1:0]            wr_en,
  input  logic [NWR*TW-1:0]         wr_tid,
  input  logic [NWR*IW-1:0]         wr_idx,
  input  logic [NWR*DW-1:0]         wr_data,
  output logic [DEPTH-1:0]          ent_we,
  output logic [DEPTH-1:0][DW-1:0]  ent_wd
);
  logic [AW-1:0] port_ent [NWR];

  for (genvar p = 0; p < NWR; p++) begin : g_addr
    assign port_ent[p] = AW'(wr_tid[p*TW +: TW]) * AW'(NREG) + AW'(wr_idx[p*IW +: IW]);
  end

  always_comb begin
    ent_we = '0;
    ent_wd = '0;
    for (int p = 0; p < NWR; p++) begin
      if (wr_en[p]) begin
        ent_we[port_ent[p]] = 1'b1;
        ent_wd[port_ent[p]] = wr_data[p*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/dup_rf_copy.sv
// One full copy of the register storage, with its local read ports.
module dup_rf_copy #(
  parameter int unsigned NRD   = 2,
  parameter int unsigned TW    = 2,
  parameter int unsigned IW    = 5,
  parameter int unsigned AW    = 7,
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          ent_we,
  input  logic [DEPTH-1:0][DW-1:0]  ent_wd,
  input  logic [NRD*TW-1:0]         rd_tid,
  input  logic [NRD*IW-1:0]         rd_idx,
  output logic [NRD*DW-1:0]         rd_data
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  // Storage: each entry is a clock-enabled register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_we[e]) mem_q[e] <= ent_wd[e];
      end
    end
  end

  // Read ports: the resolved write of this cycle bypasses the stored value.
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0] rent;
    assign rent = AW'(rd_tid[r*TW +: TW]) * AW'(NREG) + AW'(rd_idx[r*IW +: IW]);
    always_comb begin
      if (ent_we[rent]) rd_data[r*DW +: DW] = ent_wd[rent];
      else              rd_data[r*DW +: DW] = mem_q[rent];
    end
  end
endmodule

// File: rtl/dup_rf.sv
module dup_rf #(
  parameter int unsigned NTHREAD = dup_rf_pkg::THREADS_DEF,
  parameter int unsigned NREG    = dup_rf_pkg::REGS_DEF,
  parameter int unsigned DW      = dup_rf_pkg::DATA_W_DEF,
  parameter int unsigned NWR     = dup_rf_pkg::WPORTS_DEF,
  parameter int unsigned NCOPY   = dup_rf_pkg::COPIES_DEF,
  parameter int unsigned NRD     = dup_rf_pkg::RPC_DEF,
  localparam int unsigned TW     = dup_rf_pkg::clog2_min1(NTHREAD),
  localparam int unsigned IW     = dup_rf_pkg::clog2_min1(NREG),
  localparam int unsigned DEPTH  = NTHREAD * NREG,
  localparam int unsigned AW     = dup_rf_pkg::clog2_min1(DEPTH),
  localparam int unsigned NRP    = NCOPY * NRD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*TW-1:0]    wr_tid,
  input  logic [NWR*IW-1:0]    wr_idx,
  input  logic [NWR*DW-1:0]    wr_data,
  input  logic [NRP*TW-1:0]    rd_tid,
  input  logic [NRP*IW-1:0]    rd_idx,
  output logic [NRP*DW-1:0]    rd_data
);
  logic                     rst_sync_n;
  logic [DEPTH-1:0]         ent_we;
  logic [DEPTH-1:0][DW-1:0] ent_wd;

  dup_rf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dup_rf_wr_resolve #(
    .NWR(NWR), .TW(TW), .IW(IW), .AW(AW), .DW(DW), .NREG(NREG), .DEPTH(DEPTH)
  ) i_wr_resolve (
    .wr_en   (wr_en),
    .wr_tid  (wr_tid),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ent_we  (ent_we),
    .ent_wd  (ent_wd)
  );

  // One storage copy per functional unit; the resolved write reaches every copy.
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    dup_rf_copy #(
      .NRD(NRD), .TW(TW), .IW(IW), .AW(AW), .DW(DW), .NREG(NREG), .DEPTH(DEPTH)
    ) i_copy (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ent_we  (ent_we),
      .ent_wd  (ent_wd),
      .rd_tid  (rd_tid[c*NRD*TW +: NRD*TW]),
      .rd_idx  (rd_idx[c*NRD*IW +: NRD*IW]),
      .rd_data (rd_data[c*NRD*DW +: NRD*DW])
    );
  end
endmodule

// File: rtl/dup_rf_checker.sv
module dup_rf_checker #(
  parameter int unsigned NWR = 6,
  parameter int unsigned NRD = 2,
  parameter int unsigned NRP = 12,
  parameter int unsigned TW  = 2,
  parameter int unsigned IW  = 5,
  parameter int unsigned DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NWR-1:0]    wr_en,
  input logic [NWR*TW-1:0] wr_tid,
  input logic [NWR*IW-1:0] wr_idx,
  input logic [NWR*DW-1:0] wr_data,
  input logic [NRP*TW-1:0] rd_tid,
  input logic [NRP*IW-1:0] rd_idx,
  input logic [NRP*DW-1:0] rd_data
);
  localparam int unsigned KW = TW + IW;
  localparam int unsigned TOP = NWR - 1;

  logic [KW-1:0] wkey [NWR];
  logic [KW-1:0] rkey [NRP];
  logic [DW-1:0] rval [NRP];
  logic [NRP-1:0] rhit;
  logic fresh_q;

  for (genvar p = 0; p < NWR; p++) begin : g_wk
    assign wkey[p] = {wr_tid[p*TW +: TW], wr_idx[p*IW +: IW]};
  end

  for (genvar k = 0; k < NRP; k++) begin : g_rk
    assign rkey[k] = {rd_tid[k*TW +: TW], rd_idx[k*IW +: IW]};
    assign rval[k] = rd_data[k*DW +: DW];
    always_comb begin
      rhit[k] = 1'b0;
      for (int p = 0; p < NWR; p++) begin
        if (wr_en[p] && wkey[p] == rkey[k]) rhit[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b1;
    else        fresh_q <= 1'b0;
  end

  // R1: first cycle after reset, nothing written, every output is zero
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_q && wr_en == '0) |-> (rd_data == '0));

  for (genvar k = 0; k < NRP; k++) begin : g_chk
    // R5: same-cycle bypass from the top-priority port
    assert_bypass_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[TOP] && wkey[TOP] == rkey[k]) |-> (rval[k] == wr_data[TOP*DW +: DW]));

    // R4: the top-priority port's value is the one held one cycle later
    assert_top_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[TOP] |=> ((rkey[k] == $past(wkey[TOP]) && !rhit[k]) ?
                      (rval[k] == $past(wr_data[TOP*DW +: DW])) : 1'b1));

    // R7: with no enabled write, a held address keeps returning the same value
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == '0) |=> ((rkey[k] == $past(rkey[k]) && !rhit[k]) ?
                         (rval[k] == $past(rval[k])) : 1'b1));
  end

  for (genvar c = 1; c < NRP / NRD; c++) begin : g_coh
    // R2: copies agree on equal addresses (port 0 of copy c against copy 0)
    assert_copies_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rkey[c*NRD] == rkey[0]) |-> (rval[c*NRD] == rval[0]));
  end
endmodule

bind dup_rf dup_rf_checker #(
  .NWR(NWR), .NRD(NRD), .NRP(NRP), .TW(TW), .IW(IW), .DW(DW)
) i_dup_rf_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_tid  (wr_tid),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .rd_tid  (rd_tid),
  .rd_idx  (rd_idx),
  .rd_data (rd_data)
);

// File: tb/test_dup_rf.sv
module test_dup_rf;
  localparam int NWR = 6;
  localparam int NRP = 12;
  localparam int TW = 2;
  localparam int IW = 5;
  localparam int DW = 32;

  typedef struct {
    int          rp;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [NWR-1:0]    wr_en;
  logic [NWR*TW-1:0] wr_tid;
  logic [NWR*IW-1:0] wr_idx;
  logic [NWR*DW-1:0] wr_data;
  logic [NRP*TW-1:0] rd_tid;
  logic [NRP*IW-1:0] rd_idx;
  logic [NRP*DW-1:0] rd_data;

  logic [31:0] model [4][32];
  logic        d_en [NWR];
  int          d_wt [NWR];
  int          d_wi [NWR];
  logic [31:0] d_wd [NWR];
  int          d_rt [NRP];
  int          d_ri [NRP];
  sb_item_t    sbq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dup_rf i_dup_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_tid(rd_tid), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic clr();
    for (int p = 0; p < NWR; p++) begin
      d_en[p] = 1'b0; d_wt[p] = 0; d_wi[p] = 0; d_wd[p] = '0;
    end
    for (int k = 0; k < NRP; k++) begin
      d_rt[k] = 0; d_ri[k] = 0;
    end
  endtask

  task automatic wr(int p, int t, int i, logic [31:0] v);
    d_en[p] = 1'b1; d_wt[p] = t; d_wi[p] = i; d_wd[p] = v;
  endtask

  task automatic rd_all(int t, int i);
    for (int k = 0; k < NRP; k++) begin
      d_rt[k] = t; d_ri[k] = i;
    end
  endtask

  // Driver: applies one cycle and pushes the expected value for every read port.
  task automatic step(string tag, bit expect_on);
    @(negedge clk);
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = d_en[p];
      wr_tid[p*TW +: TW] = TW'(d_wt[p]);
      wr_idx[p*IW +: IW] = IW'(d_wi[p]);
      wr_data[p*DW +: DW] = d_wd[p];
    end
    for (int k = 0; k < NRP; k++) begin
      rd_tid[k*TW +: TW] = TW'(d_rt[k]);
      rd_idx[k*IW +: IW] = IW'(d_ri[k]);
    end
    if (expect_on) begin
      for (int k = 0; k < NRP; k++) begin
        sb_item_t it;
        it.rp = k;
        it.exp = model[d_rt[k]][d_ri[k]];
        for (int p = 0; p < NWR; p++)
          if (d_en[p] && d_wt[p] == d_rt[k] && d_wi[p] == d_ri[k]) it.exp = d_wd[p];
        it.tag = tag;
        sbq.push_back(it);
      end
      for (int p = 0; p < NWR; p++)
        if (d_en[p]) model[d_wt[p]][d_wi[p]] = d_wd[p];
    end
  endtask

  // Monitor: compares away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = rd_data[it.rp*DW +: DW];
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s port %0d actual=%h expected=%h", it.tag, it.rp, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 32; i++) model[t][i] = '0;
    wr_en = '0; wr_tid = '0; wr_idx = '0; wr_data = '0; rd_tid = '0; rd_idx = '0;
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R9: a write presented while the synchronised reset is still held is lost
    @(negedge clk);
    rst_n = 1'b1;
    clr(); wr(0, 1, 1, 32'hDEAD0001); step("R9", 1'b0);
    clr(); step("R9", 1'b0);
    clr(); step("R9", 1'b0);
    clr(); d_rt[0] = 1; d_ri[0] = 1; step("R9", 1'b1);

    // R1: every register of every thread reads zero, swept over twelve ports
    for (int base = 0; base < 128; base += NRP) begin
      clr();
      for (int k = 0; k < NRP; k++) begin
        d_rt[k] = ((base + k) % 128) / 32; d_ri[k] = (base + k) % 32;
      end
      step("R1", 1'b1);
    end

    // R2: a write from each port, then read from all copies
    for (int p = 0; p < NWR; p++) begin
      clr(); wr(p, p % 4, 3 + p, 32'hA5000000 + p); step("R2", 1'b1);
      clr(); rd_all(p % 4, 3 + p); step("R2", 1'b1);
    end

    // R3: same index, different threads
    clr(); wr(0, 0, 9, 32'h11111111); wr(1, 3, 9, 32'h33333333); step("R3", 1'b1);
    clr(); for (int k = 0; k < NRP; k++) begin d_rt[k] = k % 4; d_ri[k] = 9; end
    step("R3", 1'b1);

    // R4: conflicts, top port and a lower pair
    clr(); wr(1, 2, 20, 32'h00000001); wr(3, 2, 20, 32'h00000003); wr(5, 2, 20, 32'h00000005);
    step("R4", 1'b1);
    clr(); rd_all(2, 20); step("R4", 1'b1);
    clr(); wr(0, 1, 21, 32'hC0C00000); wr(2, 1, 21, 32'hC0C00002); step("R4", 1'b1);
    clr(); rd_all(1, 21); step("R4", 1'b1);

    // R5: same-cycle bypass, plain and under conflict
    clr(); wr(4, 3, 30, 32'hB0B0B0B0); rd_all(3, 30); step("R5", 1'b1);
    clr(); wr(0, 0, 31, 32'h0000E000); wr(3, 0, 31, 32'h0000E003); rd_all(0, 31); step("R5", 1'b1);

    // R7: disabled ports carry data that must not land
    for (int p = 0; p < NWR; p++) begin
      d_en[p] = 1'b0; d_wt[p] = 2; d_wi[p] = 20; d_wd[p] = 32'hFFFF0000 + p;
    end
    step("R7", 1'b1);
    clr(); rd_all(2, 20); step("R7", 1'b1);

    // R8 and R6: six distinct registers in one cycle, read back on distinct ports
    clr();
    for (int p = 0; p < NWR; p++) wr(p, p % 4, 12 + p, 32'h80000000 + 32'(p * 17));
    step("R8", 1'b1);
    clr();
    for (int k = 0; k < NRP; k++) begin d_rt[k] = (k % 6) % 4; d_ri[k] = 12 + (k % 6); end
    step("R6", 1'b1);

    // R4/R6 random traffic over a small address set to force conflicts
    for (int n = 0; n < 600; n++) begin
      clr();
      for (int p = 0; p < NWR; p++)
        if ($urandom_range(0, 1) == 1) wr(p, $urandom_range(0, 3), $urandom_range(0, 3), $urandom);
      for (int k = 0; k < NRP; k++) begin
        d_rt[k] = $urandom_range(0, 3); d_ri[k] = $urandom_range(0, 3);
      end
      step("R6", 1'b1);
    end

    clr(); step("R2", 1'b0);
    @(negedge clk); #4;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule